// File: doc/BRIEF.md
# Variable-Length Record Circular Cache

This block sits between a requester and a slow, byte-wide external memory that holds records of differing sizes, each identified by a numeric ID. A lookup by ID is accepted on a valid/ready request port. When the record is resident, its bytes are replayed from an on-chip circular byte buffer. When it is not, the block fetches the record, forwards its bytes to the requester while it writes them into the buffer, and enters it in a fully associative directory. The memory sends the payload length in the first byte of a record, and the payload bytes follow.

Records are stored end to end, starting at the buffer head and wrapping past the end of the buffer. Space is freed only at the other end of the buffer, by dropping the record that was inserted earliest. A hit never changes this order, so the free space is always a single contiguous run. A record whose length is above the programmable `max_len` limit is streamed through without being stored and without displacing anything. A length byte of zero ends the transaction with no response bytes.

Back-pressure rules are as follows. The request port takes one lookup at a time: `req_ready` is high only while the block is idle. On the response stream, `rsp_data` and `rsp_last` hold while `rsp_valid` is high and `rsp_ready` is low. While a fetched record is streaming, `mem_rd_ready` follows `rsp_ready`, so a stalled requester stalls the memory. The memory port is expected to hold `mem_rd_valid` and `mem_rd_data` until they are accepted.

Top module: `rec_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0 and both counters read 0; `req_ready` is 0 from the cycle after a request is accepted until its last response byte has gone.
- R2: A lookup whose ID is resident returns the stored payload bytes in order, flags the final byte with `rsp_last`, makes no memory request and adds 1 to `hit_count`.
- R3: A lookup that misses raises `mem_req_valid` with `mem_req_id` equal to the ID, holds it until `mem_req_ready`, reads the length L from the first returned byte, forwards the L following bytes with `rsp_last` on the final one and adds 1 to `miss_count`.
- R4: A missed record with 1 <= L <= `max_len` is inserted, so the next lookup of that ID hits; L equal to `max_len` is still cached.
- R5: A missed record with L > `max_len` is streamed through, is not inserted (a repeat lookup misses again), and evicts nothing: records resident before it still hit.
- R6: The buffer holds BUF_BYTES bytes in total. Before an insertion, records are dropped in insertion order until the free bytes are at least L. Stored bytes wrap around the buffer end, and the occupied byte count never exceeds BUF_BYTES.
- R7: A hit does not change eviction order: a record inserted earliest is dropped first even when it was hit just before.
- R8: When all DIR_ENTRIES directory slots are in use, the earliest-inserted record is dropped before an insertion, even if enough bytes are free.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_last` stay unchanged; stalling `rsp_ready` does not change the returned bytes.
- R10: Each accepted lookup adds exactly 1 to exactly one of `hit_count` or `miss_count` (bypassed records count as misses); the counters never decrease and saturate at their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_len | input | 8 | Largest payload length that is cached, in bytes |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_id | input | ID_W | Record ID to look up |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Requester accepts the response byte |
| rsp_data | output | 8 | Response payload byte |
| rsp_last | output | 1 | Final byte of the record |
| mem_req_valid | output | 1 | Fetch request to external memory |
| mem_req_ready | input | 1 | Memory accepts the fetch request |
| mem_req_id | output | ID_W | ID of the record to fetch |
| mem_rd_valid | input | 1 | Memory byte valid (length byte first, then payload) |
| mem_rd_ready | output | 1 | Block accepts the memory byte |
| mem_rd_data | input | 8 | Memory byte |
| hit_count | output | CNT_W | Lookups served from the buffer |
| miss_count | output | CNT_W | Lookups that went to memory |

## Verification
On every cycle, the checker confirms the following: the response and fetch-request handshakes stay stable under back-pressure, the occupied byte count stays within the buffer, and a bypassed record leaves the occupancy alone. It also confirms that the idle state never overlaps an active stream and that the counters step by at most one between them. Some behaviour can only be seen over whole sequences of lookups, and the directed scenarios compare it against a software model of the insertion-order policy. This covers which records survive space or directory pressure, that a hit gives no protection from eviction, that wrapped records come back intact, and where the `max_len` boundary falls.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int LEN_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIT,
    ST_MREQ,
    ST_MLEN,
    ST_EVICT,
    ST_FILL,
    ST_BYPASS
  } vrc_state_e;
endpackage

// File: rtl/vrc_directory.sv
// Fully associative record directory kept as a ring in insertion order:
// new entries go in at the head slot, evictions always take the tail slot.
module vrc_directory #(
  parameter int ID_W = 16,
  parameter int AW   = 12,
  parameter int DIRN = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          lk_id,
  output logic                     lk_hit,
  output logic [AW-1:0]            lk_start,
  output logic [vrc_pkg::LEN_W-1:0] lk_len,
  input  logic                     alloc_en,
  input  logic [ID_W-1:0]          alloc_id,
  input  logic [AW-1:0]            alloc_start,
  input  logic [vrc_pkg::LEN_W-1:0] alloc_len,
  input  logic                     evict_en,
  output logic [vrc_pkg::LEN_W-1:0] tail_len,
  output logic                     full
);
  localparam int IW = $clog2(DIRN);

  logic [DIRN-1:0]            vld_q;
  logic [ID_W-1:0]            ids_q    [DIRN];
  logic [AW-1:0]              starts_q [DIRN];
  logic [vrc_pkg::LEN_W-1:0]  lens_q   [DIRN];
  logic [IW-1:0]              head_q, tail_q;
  logic [IW:0]                cnt_q;
  logic [DIRN-1:0]            match;

  for (genvar i = 0; i < DIRN; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (ids_q[i] == lk_id);
  end

  // IDs are unique in the directory, so an OR of the gated fields is a mux.
  always_comb begin
    lk_start = '0;
    lk_len   = '0;
    for (int i = 0; i < DIRN; i++) begin
      lk_start = lk_start | (match[i] ? starts_q[i] : '0);
      lk_len   = lk_len   | (match[i] ? lens_q[i]   : '0);
    end
  end

  assign lk_hit   = |match;
  assign tail_len = lens_q[tail_q];
  assign full     = (cnt_q == (IW+1)'(DIRN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (evict_en) begin
        vld_q[tail_q] <= 1'b0;
        tail_q        <= tail_q + 1'b1;
      end
      if (alloc_en) begin
        vld_q[head_q] <= 1'b1;
        head_q        <= head_q + 1'b1;
      end
      cnt_q <= cnt_q + (IW+1)'(alloc_en) - (IW+1)'(evict_en);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      ids_q[head_q]    <= alloc_id;
      starts_q[head_q] <= alloc_start;
      lens_q[head_q]   <= alloc_len;
    end
  end
endmodule

// File: rtl/vrc_bytebuf.sv
// Circular byte store: one write port, one asynchronous read port.
module vrc_bytebuf #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/vrc_stats.sv
// Saturating hit and miss counters.
module vrc_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_inc,
  input  logic             miss_inc,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (hit_inc && (hit_count != '1))   hit_count  <= hit_count + 1'b1;
      if (miss_inc && (miss_count != '1)) miss_count <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/rec_cache.sv
// Variable-length record cache over a circular byte buffer with
// insertion-order (least recently missed) eviction and a length-limited bypass.
module rec_cache #(
  parameter int ID_W        = 16,
  parameter int BUF_BYTES   = 4096,  // power of two, at least 256
  parameter int DIR_ENTRIES = 64,    // power of two, at least 2
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       max_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_id,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             rsp_last,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [ID_W-1:0]  mem_req_id,
  input  logic             mem_rd_valid,
  output logic             mem_rd_ready,
  input  logic [7:0]       mem_rd_data,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  import vrc_pkg::*;

  localparam int AW = $clog2(BUF_BYTES);
  localparam int UW = AW + 1;

  vrc_state_e       state_q, state_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [AW-1:0]    head_q, head_d;
  logic [UW-1:0]    used_q, used_d;

  logic             lk_hit, dir_full, alloc_en, evict_en, wr_en;
  logic             hit_inc, miss_inc, need_room;
  logic [AW-1:0]    lk_start;
  logic [LEN_W-1:0] lk_len, tail_len;
  logic [7:0]       rd_data;

  vrc_directory #(.ID_W(ID_W), .AW(AW), .DIRN(DIR_ENTRIES)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_id      (req_id),
    .lk_hit     (lk_hit),
    .lk_start   (lk_start),
    .lk_len     (lk_len),
    .alloc_en   (alloc_en),
    .alloc_id   (id_q),
    .alloc_start(head_q),
    .alloc_len  (len_q),
    .evict_en   (evict_en),
    .tail_len   (tail_len),
    .full       (dir_full)
  );

  vrc_bytebuf #(.AW(AW)) u_buf (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(ptr_q),
    .wr_data(mem_rd_data),
    .rd_addr(ptr_q),
    .rd_data(rd_data)
  );

  vrc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_inc   (hit_inc),
    .miss_inc  (miss_inc),
    .hit_count (hit_count),
    .miss_count(miss_count)
  );

  // Room check for the pending insertion: bytes and a directory slot.
  assign need_room = (({1'b0, used_q} + (UW+1)'(len_q)) > (UW+1)'(BUF_BYTES)) || dir_full;

  assign mem_req_id = id_q;
  assign rsp_last   = rsp_valid && (left_q == LEN_W'(1));

  always_comb begin
    state_d       = state_q;
    id_d          = id_q;
    len_d         = len_q;
    left_d        = left_q;
    ptr_d         = ptr_q;
    head_d        = head_q;
    used_d        = used_q;
    alloc_en      = 1'b0;
    evict_en      = 1'b0;
    wr_en         = 1'b0;
    hit_inc       = 1'b0;
    miss_inc      = 1'b0;
    req_ready     = 1'b0;
    rsp_valid     = 1'b0;
    rsp_data      = rd_data;
    mem_req_valid = 1'b0;
    mem_rd_ready  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          if (lk_hit) begin
            hit_inc = 1'b1;
            ptr_d   = lk_start;
            left_d  = lk_len;
            state_d = ST_HIT;
          end else begin
            miss_inc = 1'b1;
            id_d     = req_id;
            state_d  = ST_MREQ;
          end
        end
      end
      ST_HIT: begin
        rsp_valid = 1'b1;
        if (rsp_ready) begin
          ptr_d  = ptr_q + 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == LEN_W'(1)) state_d = ST_IDLE;
        end
      end
      ST_MREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_MLEN;
      end
      ST_MLEN: begin
        mem_rd_ready = 1'b1;
        if (mem_rd_valid) begin
          len_d  = mem_rd_data;
          left_d = mem_rd_data;
          if (mem_rd_data == 8'd0)         state_d = ST_IDLE;
          else if (mem_rd_data > max_len)  state_d = ST_BYPASS;
          else                             state_d = ST_EVICT;
        end
      end
      ST_EVICT: begin
        // One oldest record leaves per cycle until the new one fits.
        if (need_room) begin
          evict_en = 1'b1;
          used_d   = used_q - UW'(tail_len);
        end else begin
          alloc_en = 1'b1;
          used_d   = used_q + UW'(len_q);
          ptr_d    = head_q;
          state_d  = ST_FILL;
        end
      end
      ST_FILL, ST_BYPASS: begin
        rsp_valid    = mem_rd_valid;
        rsp_data     = mem_rd_data;
        mem_rd_ready = rsp_ready;
        if (mem_rd_valid && rsp_ready) begin
          wr_en  = (state_q == ST_FILL);
          ptr_d  = ptr_q + 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            state_d = ST_IDLE;
            if (state_q == ST_FILL) head_d = ptr_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= '0;
      len_q   <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      head_q  <= '0;
      used_q  <= '0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
      len_q   <= len_d;
      left_q  <= left_d;
      ptr_q   <= ptr_d;
      head_q  <= head_d;
      used_q  <= used_d;
    end
  end
endmodule

// File: rtl/rec_cache_chk.sv
module rec_cache_chk #(
  parameter int ID_W      = 16,
  parameter int BUF_BYTES = 4096,
  parameter int CNT_W     = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [7:0]               rsp_data,
  input logic                     rsp_last,
  input logic                     mem_req_valid,
  input logic                     mem_req_ready,
  input logic [ID_W-1:0]          mem_req_id,
  input logic [CNT_W-1:0]         hit_count,
  input logic [CNT_W-1:0]         miss_count,
  input logic [$clog2(BUF_BYTES):0] used_bytes,
  input logic                     in_bypass
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));

  assert_memreq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_id)));

  assert_bypass_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_bypass |=> $stable(used_bytes));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    used_bytes <= ($clog2(BUF_BYTES)+1)'(BUF_BYTES));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

  assert_hit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + 1'b1)));

  assert_miss_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1)));

  assert_one_counter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_count != $past(hit_count), miss_count != $past(miss_count)}) <= 1);
endmodule

bind rec_cache rec_cache_chk #(
  .ID_W(ID_W), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_last     (rsp_last),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_id   (mem_req_id),
  .hit_count    (hit_count),
  .miss_count   (miss_count),
  .used_bytes   (used_q),
  .in_bypass    (state_q == vrc_pkg::ST_BYPASS)
);

// File: tb/rec_cache_bench.sv
`timescale 1ns/1ps
module rec_cache_bench;
  localparam int ID_W = 16;
  localparam int BUFB = 512;
  localparam int DIRN = 8;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]      max_len;
  logic            req_valid, req_ready;
  logic [ID_W-1:0] req_id;
  logic            rsp_valid, rsp_ready, rsp_last;
  logic [7:0]      rsp_data;
  logic            mem_req_valid, mem_req_ready, mem_rd_valid, mem_rd_ready;
  logic [ID_W-1:0] mem_req_id;
  logic [7:0]      mem_rd_data;
  logic [CW-1:0]   hit_count, miss_count;

  rec_cache #(.ID_W(ID_W), .BUF_BYTES(BUFB), .DIR_ENTRIES(DIRN), .CNT_W(CW)) u_rec_cache (
    .clk(clk), .rst_n(rst_n), .max_len(max_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_id(mem_req_id),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;
  bit bp      = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Record contents held by the external memory model.
  function automatic int rec_len(input int id);
    int l = id & 255;
    return (l == 0) ? 1 : l;
  endfunction
  function automatic logic [7:0] rec_byte(input int id, input int i);
    return 8'((id * 5) + (i * 3) + ((id >> 8) * 11) + 7);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Memory responder: length byte first, then payload; advances on accept.
  int mem_reqs = 0;
  int last_mem_id = -1;
  initial begin
    int cur = 0, idx = 0, len = 0;
    bit fr, fd;
    mem_req_ready = 1'b1;
    mem_rd_valid  = 1'b0;
    mem_rd_data   = 8'd0;
    forever begin
      @(negedge clk); #1;
      fr = mem_req_valid && mem_req_ready;
      fd = mem_rd_valid && mem_rd_ready;
      if (fr) last_mem_id = int'(mem_req_id);
      @(posedge clk); #1;
      if (fr) begin
        mem_reqs++;
        cur = last_mem_id; idx = 0; len = rec_len(cur);
        mem_rd_valid = 1'b1;
        mem_rd_data  = 8'(len);
      end else if (fd) begin
        idx++;
        if (idx > len) mem_rd_valid = 1'b0;
        else mem_rd_data = rec_byte(cur, idx - 1);
      end
    end
  end

  // Response collector with optional back-pressure.
  logic [7:0] rx_data [256];
  bit         rx_lst  [256];
  int         rx_n = 0;
  initial begin
    rsp_ready = 1'b1;
    forever begin
      @(negedge clk);
      rsp_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (rsp_valid && rsp_ready && rx_n < 256) begin
        rx_data[rx_n] = rsp_data;
        rx_lst[rx_n]  = rsp_last;
        rx_n++;
      end
    end
  end

  // Software model of the insertion-order policy.
  int m_id [DIRN];
  int m_len[DIRN];
  int m_cnt = 0, m_used = 0;
  function automatic bit model_access(input int id, input int ml);
    int l = rec_len(id);
    for (int i = 0; i < m_cnt; i++) if (m_id[i] == id) return 1'b1;
    if (l > ml) return 1'b0;
    while (m_used + l > BUFB || m_cnt == DIRN) begin
      m_used -= m_len[0];
      for (int i = 0; i < m_cnt - 1; i++) begin
        m_id[i] = m_id[i+1]; m_len[i] = m_len[i+1];
      end
      m_cnt--;
    end
    m_id[m_cnt] = id; m_len[m_cnt] = l; m_cnt++; m_used += l;
    return 1'b0;
  endfunction

  task automatic do_req(input int id, input string tag);
    bit exp_hit;
    int h0, m0, q0, t, exp_len, bad;
    exp_hit = model_access(id, int'(max_len));
    exp_len = rec_len(id);
    h0 = int'(hit_count); m0 = int'(miss_count); q0 = mem_reqs;
    rx_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_id = ID_W'(id);
    t = 0;
    forever begin
      #1;
      if (req_ready || t > 1000) break;
      @(negedge clk); t++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk); #1;
    check(req_ready == 1'b0, "R1", "req_ready while busy", int'(req_ready), 0);
    t = 0;
    while (!(rx_n > 0 && rx_lst[rx_n-1]) && t < 3000) begin
      @(posedge clk); t++;
    end
    repeat (2) @(negedge clk);
    #1;
    bad = -1;
    for (int i = 0; i < rx_n && i < exp_len; i++)
      if (bad < 0 && (rx_data[i] !== rec_byte(id, i) || rx_lst[i] != (i == exp_len - 1))) bad = i;
    check(rx_n == exp_len, tag, "byte count", rx_n, exp_len);
    check(bad < 0, tag, "payload byte/last flag",
          (bad < 0) ? 0 : int'(rx_data[bad]), (bad < 0) ? 0 : int'(rec_byte(id, bad)));
    check((int'(hit_count) - h0) == int'(exp_hit) && (int'(miss_count) - m0) == int'(!exp_hit),
          {tag, " R10"}, "hit/miss delta (hit*16+miss)",
          (int'(hit_count) - h0) * 16 + (int'(miss_count) - m0), int'(exp_hit) * 16 + int'(!exp_hit));
    check((mem_reqs - q0) == int'(!exp_hit), {tag, " R3"}, "memory fetches",
          mem_reqs - q0, int'(!exp_hit));
    if (!exp_hit) check(last_mem_id == id, "R3", "mem_req_id", last_mem_id, id);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1", "reset valids",
          int'(rsp_valid) + int'(mem_req_valid), 0);
    check(hit_count == 0 && miss_count == 0, "R1", "reset counters",
          int'(hit_count) + int'(miss_count), 0);
  endtask

  task automatic t_basic;
    max_len = 8'd255;
    do_req(16'h000A, "R3 first miss");
    do_req(16'h000A, "R2 hit");
    do_req(16'h0020, "R3 second miss");
    do_req(16'h000A, "R4 still cached");
  endtask

  task automatic t_bypass;
    max_len = 8'd100;
    do_req(16'h00C8, "R5 bypass");
    do_req(16'h00C8, "R5 bypass repeat");
    do_req(16'h000A, "R5 older record kept");
    do_req(16'h0064, "R4 length equals limit");
    do_req(16'h0064, "R4 limit record hits");
    max_len = 8'd255;
  endtask

  task automatic t_space;
    do_req(16'h00F0, "R6 large insert");
    do_req(16'h000A, "R7 hit on oldest");
    do_req(16'h00C0, "R6 evicting insert");
    do_req(16'h000A, "R7 oldest gone despite hit");
    do_req(16'h01F0, "R6 wrap insert");
    do_req(16'h00C0, "R6 survivor hit");
    do_req(16'h02E0, "R6 wrap insert 2");
    do_req(16'h01F0, "R6 wrapped record hit");
  endtask

  task automatic t_dirfull;
    for (int k = 1; k <= 10; k++) do_req((k << 8) | 3, "R8 small insert");
    do_req(16'h0103, "R8 oldest small evicted");
    do_req(16'h0A03, "R8 newest small hit");
  endtask

  task automatic t_backpressure;
    bp = 1;
    do_req(16'h0333, "R9 miss under stall");
    do_req(16'h0333, "R9 hit under stall");
    bp = 0;
  endtask

  initial begin
    max_len   = 8'd255;
    req_valid = 1'b0;
    req_id    = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_basic();
    t_bypass();
    t_space();
    t_dirfull();
    t_backpressure();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule